// File: doc/BRIEF.md
# Control-Word Register Datapath

This block is the execute core of a small register machine. It holds seven general-purpose registers and an ALU. A packed 14-bit control word arrives on every clock and says three things: which two operands go onto the ALU input buses, which ALU function runs, and which register, if any, takes the result at the next rising edge. Either operand selector can take the external input word in place of a register. The destination selector can also block every register write. In that case the ALU result is still visible on the output bus, so the datapath can compute a value and pass it outward without storing it.

The control word is packed from the most significant bit downward. It holds the source A selector, then the source B selector, then the destination selector, then the operation code. The ALU result is combinational from the current control word and register contents. Only the register write waits for the clock. Fetching instructions and turning them into control words are left to the surrounding logic.

Top module: `regdp_top`

## Requirements
- R1: A clock edge with `rst_n` low sets all seven registers to zero. After reset, reading any register through a pass-A control word gives 0.
- R2: The control word is packed as source A in bits 13:11, source B in bits 10:8, destination in bits 7:5 and operation in bits 4:0. A source selector of 000 puts `ext_in` on that ALU input. A value of 001 to 111 puts register 1 to 7 on it.
- R3: A destination selector of 000 writes no register. A value k from 001 to 111 writes only register k at the next rising edge and leaves the other six unchanged.
- R4: Operation 00010 gives A+B, 00101 gives A-B and 01010 gives A OR B. All results are modulo 2^DATA_W.
- R5: Operation 01000 gives A AND B, 01100 gives A XOR B, 00001 gives A+1, 00110 gives A-1 and 01110 gives NOT A.
- R6: Operation 11000 shifts A left by one bit and 10000 shifts A right by one bit. The vacated bit is filled with 0 in both cases.
- R7: Operation 00000 passes A. Any code not listed in R4 to R6 also passes A, and the destination register is still written with that value.
- R8: For add, `carry_out` is the carry out of the top bit. For subtract, `carry_out` is 1 when A < B unsigned (a borrow). For both, `zero_out` is 1 when the result is 0. For every other operation both flags are 0.
- R9: `alu_out` shows the result for the current control word in the same cycle, including when the destination selector is 000.
- R10: When a control word reads and writes the same register, the operation uses the value held before the edge. The new value is visible from the cycle after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| ctrl_word | input | 14 | Packed control word: source A, source B, destination, operation |
| ext_in | input | DATA_W | External input word, selected by a source selector of 000 |
| alu_out | output | DATA_W | Combinational ALU result |
| carry_out | output | 1 | Carry for add, borrow for subtract, else 0 |
| zero_out | output | 1 | Result is zero, for add and subtract only, else 0 |

## Verification
The case that most needs care is a control word that reads and writes the same register: the operand fetch and the write-back then meet in one cycle. The bench provokes it with directed words whose destination equals one or both sources, and it also lets random words collide by chance. In the cycle of the word, `alu_out` is compared with the model's result on the old register value. A pass-A read on the following cycle must then return the new value, and the other six registers must be unchanged.

// File: rtl/regdp_pkg.sv
// Package: shared widths, operation codes and the control word layout
// for the control-word register datapath.
package regdp_pkg;
    localparam int SEL_W = 3;
    localparam int NREG  = (1 << SEL_W) - 1;
    localparam int OP_W  = 5;
    localparam int CW_W  = 3 * SEL_W + OP_W;

    localparam logic [OP_W-1:0] OP_PASS = 5'b00000;
    localparam logic [OP_W-1:0] OP_INC  = 5'b00001;
    localparam logic [OP_W-1:0] OP_ADD  = 5'b00010;
    localparam logic [OP_W-1:0] OP_SUB  = 5'b00101;
    localparam logic [OP_W-1:0] OP_DEC  = 5'b00110;
    localparam logic [OP_W-1:0] OP_AND  = 5'b01000;
    localparam logic [OP_W-1:0] OP_OR   = 5'b01010;
    localparam logic [OP_W-1:0] OP_XOR  = 5'b01100;
    localparam logic [OP_W-1:0] OP_NOT  = 5'b01110;
    localparam logic [OP_W-1:0] OP_SHR  = 5'b10000;
    localparam logic [OP_W-1:0] OP_SHL  = 5'b11000;

    // Fields are packed from the MSB down: source A, source B, destination, op.
    typedef struct packed {
        logic [SEL_W-1:0] src_a;
        logic [SEL_W-1:0] src_b;
        logic [SEL_W-1:0] dst;
        logic [OP_W-1:0]  op;
    } ctrl_t;
endpackage

// File: rtl/regdp_regfile.sv
// Register file: NREG registers of DATA_W bits each.
// Assumes we is one-hot or all zero. All contents are exposed in parallel
// for the operand selectors. Reset is synchronous and active low.
module regdp_regfile
    import regdp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NREG-1:0]               we,
    input  logic [DATA_W-1:0]             wdata,
    output logic [NREG-1:0][DATA_W-1:0]   reg_q
);
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        // Hold register i; clear on reset, load when its enable is set.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                reg_q[i] <= '0;
            end else if (we[i]) begin
                reg_q[i] <= wdata;
            end
        end
    end
endmodule

// File: rtl/regdp_dst_decode.sv
// Destination decoder: turns a selector into one-hot register load enables.
// Code 0 gives no enable; code k (1..NREG) enables register k.
module regdp_dst_decode
    import regdp_pkg::*;
(
    input  logic [SEL_W-1:0] dst,
    output logic [NREG-1:0]  we
);
    for (genvar i = 0; i < NREG; i++) begin : g_dec
        assign we[i] = (dst == SEL_W'(i + 1));
    end
endmodule

// File: rtl/regdp_opsel.sv
// Operand selector: puts the external word (code 0) or register k (code k)
// on one ALU input bus. Purely combinational.
module regdp_opsel
    import regdp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [SEL_W-1:0]              sel,
    input  logic [DATA_W-1:0]             ext_in,
    input  logic [NREG-1:0][DATA_W-1:0]   reg_q,
    output logic [DATA_W-1:0]             bus
);
    // Compare the selector with each register code; code 0 falls through to the input word.
    always_comb begin
        bus = ext_in;
        for (int i = 0; i < NREG; i++) begin
            if (sel == SEL_W'(i + 1)) begin
                bus = reg_q[i];
            end
        end
    end
endmodule

// File: rtl/regdp_alu.sv
// ALU: computes the function chosen by op on buses a and b. Carry and zero
// are reported for add and subtract only; subtract reports a borrow as carry.
// Codes that are not defined pass a.
module regdp_alu
    import regdp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y,
    output logic              carry,
    output logic              zero
);
    logic [DATA_W:0] sum_w;
    logic [DATA_W:0] diff_w;

    assign sum_w  = {1'b0, a} + {1'b0, b};
    assign diff_w = {1'b0, a} - {1'b0, b};

    // Select the result and the flags for the current operation code.
    always_comb begin
        carry = 1'b0;
        zero  = 1'b0;
        unique case (op)
            OP_ADD: begin
                y     = sum_w[DATA_W-1:0];
                carry = sum_w[DATA_W];
                zero  = (sum_w[DATA_W-1:0] == '0);
            end
            OP_SUB: begin
                y     = diff_w[DATA_W-1:0];
                carry = diff_w[DATA_W];
                zero  = (diff_w[DATA_W-1:0] == '0);
            end
            OP_INC:  y = a + DATA_W'(1);
            OP_DEC:  y = a - DATA_W'(1);
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_NOT:  y = ~a;
            OP_SHR:  y = {1'b0, a[DATA_W-1:1]};
            OP_SHL:  y = {a[DATA_W-2:0], 1'b0};
            default: y = a;
        endcase
    end
endmodule

// File: rtl/regdp_top.sv
// Control-word register datapath top. Each cycle the control word picks two
// operands (register or external input), an ALU function and an optional
// destination register. The ALU result drives alu_out combinationally and
// is written at the next rising edge. Assumes a single clock domain and a
// synchronous active-low reset.
module regdp_top
    import regdp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CW_W-1:0]   ctrl_word,
    input  logic [DATA_W-1:0] ext_in,
    output logic [DATA_W-1:0] alu_out,
    output logic              carry_out,
    output logic              zero_out
);
    ctrl_t                        cw;
    logic [NREG-1:0][DATA_W-1:0]  reg_q;
    logic [NREG-1:0]              we;
    logic [DATA_W-1:0]            bus_a;
    logic [DATA_W-1:0]            bus_b;
    logic [DATA_W-1:0]            result;

    assign cw = ctrl_t'(ctrl_word);

    regdp_regfile #(.DATA_W(DATA_W)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .wdata (result),
        .reg_q (reg_q)
    );

    regdp_dst_decode u_dec (
        .dst (cw.dst),
        .we  (we)
    );

    regdp_opsel #(.DATA_W(DATA_W)) u_sel_a (
        .sel    (cw.src_a),
        .ext_in (ext_in),
        .reg_q  (reg_q),
        .bus    (bus_a)
    );

    regdp_opsel #(.DATA_W(DATA_W)) u_sel_b (
        .sel    (cw.src_b),
        .ext_in (ext_in),
        .reg_q  (reg_q),
        .bus    (bus_b)
    );

    regdp_alu #(.DATA_W(DATA_W)) u_alu (
        .op    (cw.op),
        .a     (bus_a),
        .b     (bus_b),
        .y     (result),
        .carry (carry_out),
        .zero  (zero_out)
    );

    assign alu_out = result;
endmodule

// File: rtl/regdp_checker.sv
// Checker: protocol and datapath properties of regdp_top, attached by bind.
// Observes the control word, outputs, load enables and register contents.
module regdp_checker
    import regdp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [CW_W-1:0]               ctrl_word,
    input logic [DATA_W-1:0]             ext_in,
    input logic [DATA_W-1:0]             alu_out,
    input logic                          carry_out,
    input logic                          zero_out,
    input logic [NREG-1:0]               we,
    input logic [NREG-1:0][DATA_W-1:0]   reg_q
);
    ctrl_t cw;
    assign cw = ctrl_t'(ctrl_word);

    // R1: a reset edge leaves every register cleared.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (reg_q == '0));

    // R3: at most one register load enable at a time.
    a_r3_single_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we));

    // R2: pass-A with source code 0 shows the external word.
    a_r2_ext_on_a: assert property (@(posedge clk) disable iff (!rst_n)
        (cw.src_a == '0 && cw.op == OP_PASS) |-> (alu_out == ext_in));

    // R8: flags stay low for every operation other than add and subtract.
    a_r8_flags_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cw.op != OP_ADD && cw.op != OP_SUB) |-> (!carry_out && !zero_out));

    // R8: zero flag agrees with the output bus for add and subtract.
    a_r8_zero_matches: assert property (@(posedge clk) disable iff (!rst_n)
        (cw.op == OP_ADD || cw.op == OP_SUB) |-> (zero_out == (alu_out == '0)));

    for (genvar i = 0; i < NREG; i++) begin : g_reg_chk
        // R10: the selected destination holds the previous cycle's result.
        a_r10_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
            (cw.dst == SEL_W'(i + 1)) |=> (reg_q[i] == $past(alu_out)));

        // R3: a register that is not the destination keeps its value.
        a_r3_others_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (cw.dst != SEL_W'(i + 1)) |=> $stable(reg_q[i]));
    end
endmodule

bind regdp_top regdp_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_word (ctrl_word),
    .ext_in    (ext_in),
    .alu_out   (alu_out),
    .carry_out (carry_out),
    .zero_out  (zero_out),
    .we        (we),
    .reg_q     (reg_q)
);

// File: tb/tb_regdp_top.sv
`timescale 1ns/1ps
module tb_regdp_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [13:0]  ctrl_word = '0;
    logic [W-1:0] ext_in = '0;
    logic [W-1:0] alu_out;
    logic         carry_out;
    logic         zero_out;

    int total = 0;
    int bad = 0;
    logic [W-1:0] m [0:7];

    regdp_top #(.DATA_W(W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_word (ctrl_word),
        .ext_in    (ext_in),
        .alu_out   (alu_out),
        .carry_out (carry_out),
        .zero_out  (zero_out)
    );

    always #2.5 clk = ~clk;

    // Reference model: returns {carry, zero, result} from the requirements.
    function automatic logic [W+1:0] model(input logic [4:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W:0] t;
        case (op)
            5'b00010: begin t = {1'b0, a} + {1'b0, b}; return {t[W], t[W-1:0] == 0, t[W-1:0]}; end
            5'b00101: begin t = {1'b0, a} - {1'b0, b}; return {a < b, t[W-1:0] == 0, t[W-1:0]}; end
            5'b01010: return {2'b00, a | b};
            5'b01000: return {2'b00, a & b};
            5'b01100: return {2'b00, a ^ b};
            5'b00001: return {2'b00, W'(a + 1)};
            5'b00110: return {2'b00, W'(a - 1)};
            5'b01110: return {2'b00, ~a};
            5'b11000: return {2'b00, a[W-2:0], 1'b0};
            5'b10000: return {2'b00, 1'b0, a[W-1:1]};
            default:  return {2'b00, a};
        endcase
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one control word, check the outputs mid-cycle, update the model after the edge.
    task automatic apply(input logic [2:0] sa, input logic [2:0] sb, input logic [2:0] d,
                         input logic [4:0] op, input logic [W-1:0] x, input string tag);
        logic [W+1:0] e;
        logic [W-1:0] a;
        logic [W-1:0] b;
        @(negedge clk);
        ctrl_word = {sa, sb, d, op};
        ext_in = x;
        #1;
        a = (sa == 0) ? x : m[sa];
        b = (sb == 0) ? x : m[sb];
        e = model(op, a, b);
        check(tag, alu_out, e[W-1:0]);
        check({tag, " R8 carry"}, {7'b0, carry_out}, {7'b0, e[W+1]});
        check({tag, " R8 zero"}, {7'b0, zero_out}, {7'b0, e[W]});
        @(posedge clk);
        if (d != 0) m[d] = e[W-1:0];
    endtask

    task automatic read_all(input string tag);
        for (int r = 1; r <= 7; r++) apply(3'(r), 3'd0, 3'd0, 5'b00000, 8'($urandom), tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int r = 0; r < 8; r++) m[r] = '0;
    endtask

    task automatic report();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        logic [4:0] ops [0:10];
        ops = '{5'b00000, 5'b00001, 5'b00010, 5'b00101, 5'b00110, 5'b01000,
                5'b01010, 5'b01100, 5'b01110, 5'b10000, 5'b11000};
        void'($urandom(32'd4242));
        for (int r = 0; r < 8; r++) m[r] = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        read_all("R1 reset state");

        // R2 R3 R7: load each register from the external word.
        for (int r = 1; r <= 7; r++) apply(3'd0, 3'd0, 3'(r), 5'b00000, 8'(r * 17 + 3), "R2 R3 load ext");
        read_all("R3 readback after loads");

        // R9 R3: destination 0 shows the result but writes nothing.
        apply(3'd1, 3'd2, 3'd0, 5'b00010, 8'h00, "R9 no-write add");
        read_all("R3 no write with dest 0");

        // R8: add wrap to zero with carry; subtract with borrow; equal subtract.
        apply(3'd0, 3'd0, 3'd1, 5'b00000, 8'hFF, "R7 load FF");
        apply(3'd0, 3'd0, 3'd2, 5'b00000, 8'h01, "R7 load 01");
        apply(3'd1, 3'd2, 3'd3, 5'b00010, 8'h00, "R4 add wrap");
        apply(3'd2, 3'd1, 3'd4, 5'b00101, 8'h00, "R4 sub borrow");
        apply(3'd1, 3'd1, 3'd5, 5'b00101, 8'h00, "R4 sub equal");
        apply(3'd1, 3'd0, 3'd0, 5'b00010, 8'h80, "R8 add ext");

        // R6: shift with both edge bits set, zero fill.
        apply(3'd0, 3'd0, 3'd6, 5'b00000, 8'h81, "R7 load 81");
        apply(3'd6, 3'd0, 3'd7, 5'b11000, 8'h00, "R6 shift left");
        apply(3'd6, 3'd0, 3'd6, 5'b10000, 8'h00, "R6 shift right");
        read_all("R6 readback");

        // R5: logic and unary operations.
        apply(3'd1, 3'd6, 3'd3, 5'b01000, 8'h00, "R5 and");
        apply(3'd1, 3'd6, 3'd4, 5'b01100, 8'h00, "R5 xor");
        apply(3'd1, 3'd0, 3'd5, 5'b00001, 8'h00, "R5 inc wrap");
        apply(3'd5, 3'd0, 3'd5, 5'b00110, 8'h00, "R5 dec wrap");
        apply(3'd6, 3'd0, 3'd2, 5'b01110, 8'h00, "R5 complement");
        apply(3'd2, 3'd6, 3'd2, 5'b01010, 8'h00, "R4 or");

        // R7: an undefined code passes A and is still written.
        apply(3'd4, 3'd1, 3'd7, 5'b00011, 8'h00, "R7 undefined code");
        apply(3'd0, 3'd1, 3'd1, 5'b11111, 8'h5A, "R7 undefined code ext");
        read_all("R7 readback");

        // R10: read and write the same register in one word.
        apply(3'd3, 3'd3, 3'd3, 5'b00010, 8'h00, "R10 same reg add");
        apply(3'd3, 3'd0, 3'd3, 5'b00001, 8'h00, "R10 same reg inc");
        apply(3'd3, 3'd0, 3'd0, 5'b00000, 8'h00, "R10 readback");

        // Random mix across all operations and selectors.
        for (int k = 0; k < 400; k++) begin
            logic [4:0] op;
            op = ($urandom % 12 == 0) ? 5'($urandom) : ops[$urandom % 11];
            apply(3'($urandom), 3'($urandom), 3'($urandom), op, 8'($urandom), "R4 R5 R6 R7 R10 random");
        end
        read_all("R3 random readback");

        // R1: reset mid-run clears everything.
        do_reset();
        read_all("R1 mid-run reset");

        report();
    end
endmodule